// File: doc/BRIEF.md
# SPI Master with Register Port

This block is an SPI master controlled through a small 32-bit register port. Software loads up to 128 bits of outgoing data into a data window of four words, sets the clock divider, raises the slave-select lines it wants, and then writes the control register with the go/busy bit set. The controller then generates the serial clock, shifts the data out on MOSI and shifts the bits it samples from MISO into the same window. Software polls go/busy until hardware clears it and reads the received bits back from the window.

The character length, the SCLK edge on which MOSI changes, and the SCLK edge on which MISO is sampled are all set in the control register. The edge choices are independent of each other. Slave-select lines come only from their register and are never toggled by a transfer. SCLK rests low between transfers. While a transfer runs, writes to the control, divider and data registers are dropped. The slave-select register can still be written.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, reading any register returns 0, `sclk` and `mosi` are 0, and every `ss_n` line is 1.
- R2: Word addresses 0 to 3 hold data window bits [31:0], [63:32], [95:64] and [127:96]. Address 4 is control, 5 is the divider and 6 is slave select. Any other address reads 0. A write changes only the byte lanes whose `reg_wstrb` bit is set. `reg_rdata` shows the addressed register in the same cycle.
- R3: A control write that sets bit 8 (go/busy) while idle starts a transfer. Bit 8 then reads 1 for exactly 2·N·(D+1) cycles and hardware clears it, where N is the bit count and D is the divider value.
- R4: `sclk` is low whenever no transfer runs. During a transfer each half period lasts D+1 clock cycles. The first edge is rising, and there are exactly N rising edges and N falling edges.
- R5: Control bits [6:0] give N. A value of 0 means 128 bits.
- R6: MOSI sends window bits N-1 down to 0, most significant first.
- R7: Control bit 10 set means MISO is sampled on the falling SCLK edge; clear means the rising edge. After the transfer the window equals (old window << N) | received bits, kept to 128 bits. The first received bit ends up at position N-1.
- R8: Slave-select bits [SS_W-1:0] drive `ss_n` inverted: a 1 in the register drives the line low. The register can be written during a transfer, and `ss_n` changes only through such a write.
- R9: While a transfer runs, writes to the control, divider and data registers have no effect. A go bit written during a transfer starts nothing.
- R10: Control bit 9 set means MOSI takes its first bit at the start and changes only on falling SCLK edges. Clear means MOSI changes only on rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_wstrb | input | 4 | Byte-lane write enables |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 8 | Active-low slave selects |

## Verification
The assertions assume that the slave changes MISO only on the SCLK edge opposite to the sampling edge. They also assume that a go request arrives through byte lane 1 of a control write. The bench's slave model follows both rules: it updates MISO half a cycle after the non-sampling edge, and it issues every control write with all byte lanes enabled. Divider values are kept small so that each transfer finishes in a few hundred cycles. The writes that are expected to be ignored are placed well inside a transfer that is long enough to contain them.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned GO_POS  = 8;
    localparam int unsigned TXF_POS = 9;
    localparam int unsigned RXF_POS = 10;

    // byte-lane merge of a register write
    function automatic logic [REG_W-1:0] lane_merge(input logic [REG_W-1:0] old_v,
                                                    input logic [REG_W-1:0] new_v,
                                                    input logic [REG_W/8-1:0] be);
        logic [REG_W-1:0] r;
        for (int b = 0; b < REG_W/8; b++)
            r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
        return r;
    endfunction
endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
    } st_t;

    st_t s_q, s_d;
    logic flip;

    always_comb begin
        s_d  = s_q;
        flip = 1'b0;
        if (!run) begin
            s_d.cnt  = '0;
            s_d.sclk = 1'b0;
        end else if (s_q.cnt == div) begin
            flip     = 1'b1;
            s_d.cnt  = '0;
            s_d.sclk = ~s_q.sclk;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    assign rise = flip && !s_q.sclk;
    assign fall = flip &&  s_q.sclk;
    assign sclk = s_q.sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/spim_engine.sv
module spim_engine #(
    parameter int WIN_W = 128,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cfg_bits,
    input  logic             cfg_txf,
    input  logic             cfg_rxf,
    input  logic [WIN_W-1:0] tx_data,
    input  logic             rise,
    input  logic             fall,
    output logic             busy,
    output logic             mosi,
    output logic             sample
);
    typedef struct packed {
        logic             busy;
        logic             txf;
        logic             rxf;
        logic [CNT_W-1:0] nbits;
        logic [CNT_W-1:0] falls;
        logic [WIN_W-1:0] txsr;
        logic             mosi;
    } st_t;

    st_t s_q, s_d;
    logic [CNT_W-1:0] lead;
    logic [WIN_W-1:0] aligned;
    logic             last;

    always_comb begin
        s_d     = s_q;
        sample  = 1'b0;
        lead    = CNT_W'(WIN_W) - cfg_bits;
        aligned = tx_data << lead;
        last    = (s_q.falls == s_q.nbits - 1'b1);
        if (start) begin
            s_d.busy  = 1'b1;
            s_d.txf   = cfg_txf;
            s_d.rxf   = cfg_rxf;
            s_d.nbits = cfg_bits;
            s_d.falls = '0;
            s_d.mosi  = aligned[WIN_W-1];
            s_d.txsr  = aligned << 1;
        end else if (s_q.busy) begin
            if (rise) begin
                sample = !s_q.rxf;
                if (!s_q.txf && s_q.falls != '0) begin
                    s_d.mosi = s_q.txsr[WIN_W-1];
                    s_d.txsr = s_q.txsr << 1;
                end
            end
            if (fall) begin
                sample    = s_q.rxf;
                s_d.falls = s_q.falls + 1'b1;
                if (s_q.txf && !last) begin
                    s_d.mosi = s_q.txsr[WIN_W-1];
                    s_d.txsr = s_q.txsr << 1;
                end
                if (last) s_d.busy = 1'b0;
            end
        end
    end

    assign busy = s_q.busy;
    assign mosi = s_q.mosi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int DATA_WORDS = 4,
    parameter int SS_W       = 8,
    parameter int DIV_W      = 16,
    localparam int ADDR_W    = $clog2(DATA_WORDS + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [REG_W/8-1:0] reg_wstrb,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [SS_W-1:0]   ss_n
);
    localparam int WIN_W = DATA_WORDS * REG_W;
    localparam int LEN_W = $clog2(WIN_W);
    localparam int CNT_W = LEN_W + 1;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(DATA_WORDS);
    localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(DATA_WORDS + 1);
    localparam logic [ADDR_W-1:0] A_SS   = ADDR_W'(DATA_WORDS + 2);

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [LEN_W-1:0] len;
        logic             txf;
        logic             rxf;
        logic [DIV_W-1:0] div;
        logic [SS_W-1:0]  ss;
    } st_t;

    st_t r_q, r_d;

    logic             busy, start, sample, rise, fall;
    logic [CNT_W-1:0] cfg_bits;
    logic [REG_W-1:0] ctrl_view, ctrl_new, div_new, ss_new;
    logic [REG_W-1:0] word_view [DATA_WORDS];
    logic [DIV_W-1:0] div_now;
    logic             txf_now;
    logic             wr;

    genvar g;
    generate
        for (g = 0; g < DATA_WORDS; g++) begin : g_word
            assign word_view[g] = r_q.win[g*REG_W +: REG_W];
        end
    endgenerate

    always_comb begin
        ctrl_view              = '0;
        ctrl_view[LEN_W-1:0]   = r_q.len;
        ctrl_view[GO_POS]      = busy;
        ctrl_view[TXF_POS]     = r_q.txf;
        ctrl_view[RXF_POS]     = r_q.rxf;
    end

    assign wr       = reg_valid && reg_write;
    assign ctrl_new = lane_merge(ctrl_view, reg_wdata, reg_wstrb);
    assign div_new  = lane_merge(REG_W'(r_q.div), reg_wdata, reg_wstrb);
    assign ss_new   = lane_merge(REG_W'(r_q.ss), reg_wdata, reg_wstrb);

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        if (wr && !busy) begin
            for (int w = 0; w < DATA_WORDS; w++)
                if (reg_addr == ADDR_W'(w))
                    r_d.win[w*REG_W +: REG_W] =
                        lane_merge(word_view[w], reg_wdata, reg_wstrb);
            if (reg_addr == A_CTRL) begin
                r_d.len = ctrl_new[LEN_W-1:0];
                r_d.txf = ctrl_new[TXF_POS];
                r_d.rxf = ctrl_new[RXF_POS];
                start   = ctrl_new[GO_POS];
            end
            if (reg_addr == A_DIV) r_d.div = div_new[DIV_W-1:0];
        end
        if (wr && reg_addr == A_SS) r_d.ss = ss_new[SS_W-1:0];
        if (sample) r_d.win = {r_q.win[WIN_W-2:0], miso};
    end

    assign cfg_bits = (r_d.len == '0) ? CNT_W'(WIN_W) : {1'b0, r_d.len};

    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < DATA_WORDS; w++)
            if (reg_addr == ADDR_W'(w)) reg_rdata = word_view[w];
        if (reg_addr == A_CTRL) reg_rdata = ctrl_view;
        if (reg_addr == A_DIV)  reg_rdata = REG_W'(r_q.div);
        if (reg_addr == A_SS)   reg_rdata = REG_W'(r_q.ss);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    spim_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .div  (r_q.div),
        .sclk (sclk),
        .rise (rise),
        .fall (fall)
    );

    spim_engine #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cfg_bits(cfg_bits),
        .cfg_txf (r_d.txf),
        .cfg_rxf (r_d.rxf),
        .tx_data (r_q.win),
        .rise    (rise),
        .fall    (fall),
        .busy    (busy),
        .mosi    (mosi),
        .sample  (sample)
    );

    assign ss_n    = ~r_q.ss;
    assign div_now = r_q.div;
    assign txf_now = r_q.txf;
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk #(
    parameter int ADDR_W     = 3,
    parameter int DIV_W      = 16,
    parameter int SS_W       = 8,
    parameter int DATA_WORDS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_valid,
    input logic              reg_write,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              go_lane,
    input logic              go_bit,
    input logic              sclk,
    input logic              mosi,
    input logic [SS_W-1:0]   ss_n,
    input logic              xfer_busy,
    input logic [DIV_W-1:0]  div_now,
    input logic              txf_now
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(DATA_WORDS);
    localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(DATA_WORDS + 1);
    localparam logic [ADDR_W-1:0] A_SS   = ADDR_W'(DATA_WORDS + 2);

    p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_busy |-> !sclk);

    p_end_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_busy) |-> $fell(sclk));

    p_go_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && reg_addr == A_CTRL && go_lane && go_bit && !xfer_busy)
        |=> xfer_busy);

    p_div_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && reg_valid && reg_write && reg_addr == A_DIV) |=> $stable(div_now));

    p_ss_only_by_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_valid && reg_write && reg_addr == A_SS) |=> $stable(ss_n));

    p_mosi_steady_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk) && txf_now) |-> $stable(mosi));

    p_mosi_steady_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sclk) && !txf_now) |-> $stable(mosi));
endmodule

bind spim_ctrl spim_ctrl_chk #(
    .ADDR_W(ADDR_W), .DIV_W(DIV_W), .SS_W(SS_W), .DATA_WORDS(DATA_WORDS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_valid(reg_valid),
    .reg_write(reg_write),
    .reg_addr (reg_addr),
    .go_lane  (reg_wstrb[1]),
    .go_bit   (reg_wdata[8]),
    .sclk     (sclk),
    .mosi     (mosi),
    .ss_n     (ss_n),
    .xfer_busy(busy),
    .div_now  (div_now),
    .txf_now  (txf_now)
);

// File: tb/spim_ctrl_bench.sv
`timescale 1ns/1ps
module spim_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_wstrb = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi;
    logic        miso = 1'b0;
    logic [7:0]  ss_n;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    spim_ctrl u_spim_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wstrb(reg_wstrb),
        .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    typedef struct {
        int           n;
        int           d;
        bit           txf;
        bit           rxf;
        logic [127:0] txd;
        logic [127:0] pat;
    } item_t;

    item_t q[$];
    bit    mon_active = 0;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] lowmask(input int n);
        return (n >= 128) ? '1 : ((128'(1) << n) - 128'(1));
    endfunction

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d; reg_wstrb = be;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0; reg_wstrb = '0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // monitor + slave model: pops expected item, answers on MISO, captures MOSI
    int           m_ev, m_cyc, m_rises, m_ridx;
    bit           m_hp_bad, m_prev;
    logic [127:0] m_cap;
    item_t        m_it;
    initial begin
        forever begin
            @(negedge clk);
            if (!mon_active) begin
                if (q.size() > 0) begin
                    m_it = q.pop_front();
                    mon_active = 1; m_ev = 0; m_cyc = 0; m_rises = 0;
                    m_hp_bad = 0; m_cap = '0; m_ridx = m_it.n - 1;
                    if (!m_it.rxf) miso = m_it.pat[m_ridx];
                end
            end else begin
                m_cyc++;
                if (sclk !== m_prev) begin
                    if (m_ev > 0 && m_cyc != m_it.d + 1) m_hp_bad = 1;
                    m_cyc = 0; m_ev++;
                    if (sclk) begin
                        m_rises++;
                        if (m_it.txf) m_cap = {m_cap[126:0], mosi};
                        if (m_it.rxf) begin
                            miso = m_it.pat[m_ridx];
                            m_ridx--;
                        end
                    end else begin
                        if (!m_it.txf) m_cap = {m_cap[126:0], mosi};
                        if (!m_it.rxf) begin
                            m_ridx--;
                            if (m_ridx >= 0) miso = m_it.pat[m_ridx];
                        end
                    end
                    if (m_ev == 2 * m_it.n) begin
                        chk("R4 rising edge count", 128'(m_rises), 128'(m_it.n));
                        chk("R4 half period length", 128'(m_hp_bad), 128'(0));
                        chk("R6/R10 bits seen on MOSI", m_cap & lowmask(m_it.n),
                            m_it.txd & lowmask(m_it.n));
                        mon_active = 0;
                    end
                end
            end
            m_prev = sclk;
        end
    end

    task automatic run_xfer(input int nf, input int d, input bit txf, input bit rxf,
                            input logic [127:0] txd, input logic [127:0] pat, input bit poke);
        int n, cnt;
        logic [31:0] rd, ctrl_w;
        logic [127:0] expw;
        item_t it;
        n = (nf == 0) ? 128 : nf;
        for (int w = 0; w < 4; w++) reg_wr(3'(w), txd[w*32 +: 32], 4'hF);
        reg_wr(3'd5, 32'(d), 4'hF);
        it.n = n; it.d = d; it.txf = txf; it.rxf = rxf; it.txd = txd; it.pat = pat;
        q.push_back(it);
        @(negedge clk);
        ctrl_w = (32'(rxf) << 10) | (32'(txf) << 9) | 32'h100 | 32'(nf);
        reg_wr(3'd4, ctrl_w, 4'hF);
        if (poke) begin
            reg_wr(3'd5, 32'(d + 5), 4'hF);
            reg_wr(3'd0, ~txd[31:0], 4'hF);
            reg_wr(3'd4, 32'h0000_0105, 4'hF);
            reg_wr(3'd6, 32'h0000_00A0, 4'hF);
            #1 chk("R8 ss write during transfer", 128'(ss_n), 128'(8'h5F));
        end
        reg_addr = 3'd4;
        #1 rd = reg_rdata;
        cnt = 0;
        while (rd[8]) begin
            cnt++;
            @(negedge clk);
            #1 rd = reg_rdata;
        end
        if (!poke) begin
            if (nf == 0) chk("R5 length 0 means 128, busy cycles", 128'(cnt), 128'(256 * (d + 1)));
            else         chk("R3 go/busy duration", 128'(cnt), 128'(2 * n * (d + 1)));
        end
        chk("R4 sclk low after transfer", 128'(sclk), 128'(0));
        while (mon_active || q.size() > 0) @(negedge clk);
        expw = (txd << n) | (pat & lowmask(n));
        for (int w = 0; w < 4; w++) begin
            reg_rd(3'(w), rd);
            chk("R7 received window word", 128'(rd), 128'(expw[w*32 +: 32]));
        end
        if (poke) begin
            reg_rd(3'd5, rd);
            chk("R9 divider write ignored", 128'(rd), 128'(d));
            repeat (3) @(negedge clk);
            reg_rd(3'd4, rd);
            chk("R9 control write and go ignored", 128'(rd), 128'(ctrl_w & ~32'h100));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            reg_rd(3'(a), rd);
            chk("R1 reset read", 128'(rd), 128'(0));
        end
        chk("R1 sclk idle", 128'(sclk), 128'(0));
        chk("R1 mosi idle", 128'(mosi), 128'(0));
        chk("R1 ss_n deasserted", 128'(ss_n), 128'(8'hFF));
        // R2 byte lanes and address map
        reg_wr(3'd1, 32'hAABB_CCDD, 4'hF);
        reg_wr(3'd1, 32'h0000_1100, 4'b0010);
        reg_rd(3'd1, rd);
        chk("R2 byte lane write", 128'(rd), 128'(32'hAABB_11DD));
        reg_wr(3'd7, 32'hFFFF_FFFF, 4'hF);
        reg_rd(3'd7, rd);
        chk("R2 unmapped reads 0", 128'(rd), 128'(0));
        // R8 slave select
        reg_wr(3'd6, 32'h0000_0005, 4'hF);
        #1 chk("R8 ss_n follows register", 128'(ss_n), 128'(8'hFA));
        reg_rd(3'd6, rd);
        chk("R8 ss readback", 128'(rd), 128'(5));
        // transfers in each edge combination
        run_xfer(8,  0, 1'b1, 1'b0, 128'hA5, 128'h3C, 1'b0);
        run_xfer(8,  2, 1'b0, 1'b1, 128'h1234_5678_9ABC_DEF0_0F1E_2D3C_4B5A_6978, 128'hC3, 1'b0);
        run_xfer(13, 1, 1'b1, 1'b1, 128'h0BAD_F00D_1357_9BDF, 128'h1ACE, 1'b0);
        run_xfer(1,  0, 1'b0, 1'b0, 128'h1, 128'h0, 1'b0);
        run_xfer(0,  0, 1'b0, 1'b0, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_FEDC_BA98,
                 128'h5555_AAAA_0F0F_F0F0_3333_CCCC_1111_EEEE, 1'b0);
        run_xfer(32, 3, 1'b1, 1'b0, 128'h0000_0000_8001_7FFE, 128'hCAFE_0001, 1'b1);
        chk("R8 ss_n unchanged by transfers", 128'(ss_n), 128'(8'h5F));
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule